// File: doc/BRIEF.md
# Speculative Three-Level Chained Table Lookup

This block resolves an index through three lookup tables in series. The incoming index addresses the first table. That entry addresses the second table, whose entry addresses the third. The third table's entry is the result. Each table read takes two pipeline stages, so the block accepts one index per clock while up to six lookups are in flight. The pipeline assumes the tables are stable and does not stall for them.

The tables can be rewritten at any time through a per-table write port. A single update event may touch any subset of the three tables. Some in-flight items are already past the read stage of the deepest table written in the event. Those items continue and deliver results built from the older contents. Every younger item is discarded and placed, oldest first, at the front of a small reissue queue. The queue feeds them back into the pipeline before any new input is taken, so they read the updated contents and the results still leave in acceptance order. The input handshake drops ready during the write cycle and while reissue is pending.

Top module: `chain_lookup_spec`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Each result equals T2[T1[T0[idx]]], where T0, T1 and T2 are the tables written through write lanes 0, 1 and 2. Every table has 2^AW entries of AW bits, so each entry is directly the next table's address.
- R3: With no writes, `in_ready` stays high and one index is accepted on every clock. The result of an index accepted at clock edge a is presented on `out_valid`/`out_data` right after edge a+5.
- R4: Results leave in the order their indices were accepted, with none lost and none duplicated.
- R5: `in_ready` is 0 in any cycle where a `wr_en` bit is set, and in every cycle while discarded items are still waiting to be reissued.
- R6: A write on lane k updates the entry at the clock edge. Say an item was accepted at edge a. During the cycle after edge a+s, the item is in stage s, and it reads table k on its way out of stage 2k. Every item in a stage ≤ 2k at the write edge is discarded and reissued, including the item reading table k at that same edge. Its result is then computed from the updated tables.
- R7: Items in a stage above 2k at the write edge are not disturbed. Their results use the table contents from before the write.
- R8: When several lanes write in one cycle, the discard depth is set by the highest-numbered lane written.
- R9: An item that was discarded and reissued delivers its result no later than 4·NTAB−1 edges after its original acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input index offered |
| in_ready | output | 1 | Block takes the offered index this cycle |
| in_idx | input | AW | Index into the first table |
| wr_en | input | NTAB | Per-table write enable, bit k for table k |
| wr_addr | input | NTAB×AW | Per-table write address, lane k in bits [k·AW +: AW] |
| wr_data | input | NTAB×AW | Per-table write data, lane k in bits [k·AW +: AW] |
| out_valid | output | 1 | Result strobe |
| out_data | output | AW | Final table value |

## Verification
The bench builds the block with AW=3 and the default NTAB=3, which gives three 8-entry tables. At that size every index is swept twice with no writes, and all seven non-empty write-lane combinations are each fired at three different points of a full pipeline. Each lane-0 write targets the address that the item reading table 0 uses on that same edge. Because the tables are so small, the bench keeps a full copy of every table generation. It decides from stage arithmetic alone whether each in-flight item should see the old or the new contents.

// File: rtl/chain_lut_pkg.sv
`timescale 1ns/1ps
package chain_lut_pkg;

  // Number of leading pipeline stages discarded by a write event:
  // stages 0 .. 2*k_hi where k_hi is the highest lane written.
  function automatic int squash_span(input logic [15:0] mask, input int ntab);
    int span;
    span = 0;
    for (int k = 0; k < 16; k++) begin
      if (k < ntab && mask[k]) span = 2 * k + 1;
    end
    return span;
  endfunction

  // Stage s feeds a table read on its way to stage s+1.
  function automatic bit reads_table(input int s, input int ntab);
    return (s % 2 == 0) && (s / 2 < ntab);
  endfunction

  // Upper bound on acceptance-to-result edges for a reissued item.
  function automatic int worst_latency(input int ntab);
    return 4 * ntab - 1;
  endfunction

endpackage

// File: rtl/chain_lut_bank.sv
`timescale 1ns/1ps
module chain_lut_bank #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] mem [DEPTH];

  // Write lands at the edge; the read below is sampled by the stage
  // register at that same edge and so still sees the old entry.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/chain_replay_q.sv
`timescale 1ns/1ps
module chain_replay_q #(
  parameter int AW = 8,
  parameter int QD = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_en,
  input  logic [$clog2(QD+1)-1:0]  push_cnt,
  input  logic [QD-1:0][AW-1:0]    push_idx,
  input  logic                     pop,
  output logic [AW-1:0]            head,
  output logic [$clog2(QD+1)-1:0]  count,
  output logic                     empty
);
  localparam int CW = $clog2(QD + 1);
  localparam int IW = $clog2(QD);

  logic [QD-1:0][AW-1:0] q, nq;
  logic [CW-1:0]         cnt, ncnt;

  // Discarded items are older than anything already queued, so they
  // are placed in front; a pop shifts everything down by one.
  always_comb begin
    nq   = q;
    ncnt = cnt;
    if (push_en) begin
      for (int i = 0; i < QD; i++) begin
        if (i < int'(push_cnt)) nq[i] = push_idx[IW'(i)];
        else                    nq[i] = q[IW'(i - int'(push_cnt))];
      end
      ncnt = cnt + push_cnt;
    end else if (pop) begin
      for (int i = 0; i < QD - 1; i++) nq[i] = q[IW'(i + 1)];
      nq[QD-1] = '0;
      ncnt     = cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      cnt <= '0;
    end else begin
      q   <= nq;
      cnt <= ncnt;
    end
  end

  assign head  = q[0];
  assign count = cnt;
  assign empty = (cnt == '0);

  AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> (int'(cnt) + int'(push_cnt) <= QD));                 // R9
  AST_RQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));                                            // R5
  AST_RQ_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_en && pop));                                              // R5

endmodule

// File: rtl/chain_pipe.sv
`timescale 1ns/1ps
module chain_pipe
  import chain_lut_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NTAB = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           iss_valid,
  input  logic [AW-1:0]                  iss_idx,
  input  logic [NTAB-1:0]                wr_mask,
  output logic [NTAB-1:0][AW-1:0]        tbl_addr,
  input  logic [NTAB-1:0][AW-1:0]        tbl_data,
  output logic [$clog2(2*NTAB)-1:0]      sq_cnt,
  output logic [2*NTAB-2:0][AW-1:0]      sq_idx,
  output logic                           s0_valid,
  output logic [AW-1:0]                  s0_idx,
  output logic                           out_valid,
  output logic [AW-1:0]                  out_data
);
  localparam int NST = 2 * NTAB;
  localparam int QD  = 2 * NTAB - 1;
  localparam int CW  = $clog2(QD + 1);
  localparam int IW  = $clog2(QD);

  logic [NST-1:0] stage_v;
  logic [AW-1:0]  orig    [NST];
  logic [AW-1:0]  val     [NST];
  logic [AW-1:0]  nxt_val [NST];
  int             span;
  logic [CW-1:0]  cnt;

  always_comb span = squash_span(16'(wr_mask), NTAB);

  // Stage data path: even stages hand their value to a table read,
  // odd stages forward the read result unchanged.
  assign nxt_val[0] = iss_idx;
  for (genvar s = 1; s < NST; s++) begin : g_stage
    if (reads_table(s - 1, NTAB)) begin : g_rd
      assign nxt_val[s] = tbl_data[(s-1)/2];
    end else begin : g_cp
      assign nxt_val[s] = val[s-1];
    end
  end

  for (genvar k = 0; k < NTAB; k++) begin : g_addr
    assign tbl_addr[k] = val[2*k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_v <= '0;
    end else begin
      stage_v[0] <= iss_valid;
      for (int s = 1; s < NST; s++) begin
        stage_v[s] <= stage_v[s-1] && ((s - 1) >= span);
      end
    end
  end

  always_ff @(posedge clk) begin
    orig[0] <= iss_idx;
    for (int s = 1; s < NST; s++) orig[s] <= orig[s-1];
    for (int s = 0; s < NST; s++) val[s]  <= nxt_val[s];
  end

  // Collect discarded items, oldest (deepest stage) first.
  always_comb begin
    sq_idx = '0;
    cnt    = '0;
    for (int s = QD - 1; s >= 0; s--) begin
      if (s < span && stage_v[s]) begin
        sq_idx[cnt[IW-1:0]] = orig[s];
        cnt = cnt + CW'(1);
      end
    end
  end

  assign sq_cnt    = cnt;
  assign s0_valid  = stage_v[0];
  assign s0_idx    = orig[0];
  assign out_valid = stage_v[NST-1];
  assign out_data  = val[NST-1];

  AST_WRITE_CLEARS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_mask) |=> !stage_v[1]);                                     // R6
  AST_LAST_TABLE_EMPTIES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask[NTAB-1] |=> !out_valid);                                 // R8
  AST_DEEP_ITEM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask == NTAB'(1) && stage_v[2]) |=> stage_v[3]);             // R7

endmodule

// File: rtl/chain_lookup_spec.sv
`timescale 1ns/1ps
module chain_lookup_spec #(
  parameter int AW   = 8,
  parameter int NTAB = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [AW-1:0]           in_idx,
  input  logic [NTAB-1:0]         wr_en,
  input  logic [NTAB-1:0][AW-1:0] wr_addr,
  input  logic [NTAB-1:0][AW-1:0] wr_data,
  output logic                    out_valid,
  output logic [AW-1:0]           out_data
);
  localparam int QD = 2 * NTAB - 1;
  localparam int CW = $clog2(QD + 1);

  logic [NTAB-1:0][AW-1:0] tbl_addr, tbl_data;
  logic [CW-1:0]           sq_cnt, rq_count;
  logic [QD-1:0][AW-1:0]   sq_idx;
  logic [AW-1:0]           rq_head, iss_idx, s0_idx;
  logic                    rq_empty, rq_pop, iss_valid, s0_valid;
  logic                    squash_any, in_fire;

  for (genvar k = 0; k < NTAB; k++) begin : g_bank
    chain_lut_bank #(.AW(AW)) u_bank (
      .clk     (clk),
      .wr_en   (wr_en[k]),
      .wr_addr (wr_addr[k]),
      .wr_data (wr_data[k]),
      .rd_addr (tbl_addr[k]),
      .rd_data (tbl_data[k])
    );
  end

  assign squash_any = |wr_en;
  assign rq_pop     = !rq_empty && !squash_any;
  assign in_ready   = rq_empty && !squash_any;
  assign in_fire    = in_valid && in_ready;
  assign iss_valid  = rq_pop || in_fire;
  assign iss_idx    = rq_empty ? in_idx : rq_head;

  chain_replay_q #(.AW(AW), .QD(QD)) u_rq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (squash_any),
    .push_cnt (sq_cnt),
    .push_idx (sq_idx),
    .pop      (rq_pop),
    .head     (rq_head),
    .count    (rq_count),
    .empty    (rq_empty)
  );

  chain_pipe #(.AW(AW), .NTAB(NTAB)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_idx   (iss_idx),
    .wr_mask   (wr_en),
    .tbl_addr  (tbl_addr),
    .tbl_data  (tbl_data),
    .sq_cnt    (sq_cnt),
    .sq_idx    (sq_idx),
    .s0_valid  (s0_valid),
    .s0_idx    (s0_idx),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  AST_ACCEPT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (s0_valid && s0_idx == $past(in_idx)));               // R4
  AST_BUSY_AFTER_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_any && sq_cnt != '0) |=> (!in_ready && rq_count != '0));  // R5

endmodule

// File: tb/tb_chain_lookup_spec.sv
`timescale 1ns/1ps
module tb_chain_lookup_spec;
  localparam int AW   = 3;
  localparam int NTAB = 3;
  localparam int D    = 8;
  localparam int QN   = 2048;

  logic                    clk = 0;
  logic                    rst_n = 0;
  logic                    in_valid = 0;
  logic                    in_ready;
  logic [AW-1:0]           in_idx = '0;
  logic [NTAB-1:0]         wr_en = '0;
  logic [NTAB-1:0][AW-1:0] wr_addr = '0;
  logic [NTAB-1:0][AW-1:0] wr_data = '0;
  logic                    out_valid;
  logic [AW-1:0]           out_data;

  chain_lookup_spec #(.AW(AW), .NTAB(NTAB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int ec = 0;
  always @(posedge clk) ec <= ec + 1;

  int checks = 0, errors = 0;
  int cur [3][D];
  int eps [64][3][D];
  int ep = 0;
  int qi [QN], qe [QN], qa [QN], qs [QN], qt [QN];
  int hd = 0, tl = 0;
  int sidx = 0;
  bit after_sq = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, ec);
    end
  endtask

  function automatic int chain(input int e, input int i);
    return eps[e][2][eps[e][1][eps[e][0][i]]];
  endfunction

  task automatic monitor();
    int ex, lat;
    if (out_valid) begin
      if (hd == tl) chk(0, "R4", 1, 0);
      else begin
        ex = chain(qe[hd], qi[hd]);
        case (qt[hd])
          1:       chk(out_data == AW'(ex), "R6", int'(out_data), ex);
          2:       chk(out_data == AW'(ex), "R7", int'(out_data), ex);
          3:       chk(out_data == AW'(ex), "R8", int'(out_data), ex);
          default: chk(out_data == AW'(ex), "R2", int'(out_data), ex);
        endcase
        lat = ec - qa[hd];
        if (qs[hd] != 0) chk(lat <= 4 * NTAB - 1, "R9", lat, 4 * NTAB - 1);
        else             chk(lat == 5, "R3", lat, 5);
        hd++;
      end
    end
  endtask

  task automatic cycle(input bit iv, input bit [2:0] m, input int wa[3],
                       input int wd[3], input bit want_ready);
    int l, n;
    @(negedge clk);
    monitor();
    in_valid = iv;
    in_idx   = AW'(sidx);
    wr_en    = m;
    for (int k = 0; k < 3; k++) begin
      wr_addr[k] = AW'(wa[k]);
      wr_data[k] = AW'(wd[k]);
    end
    #1;
    if (after_sq) begin
      chk(in_ready == 1'b0, "R5", int'(in_ready), 0);
      after_sq = 0;
    end
    if (want_ready) chk(in_ready == 1'b1, "R3", int'(in_ready), 1);
    if (m != 0) begin
      chk(in_ready == 1'b0, "R5", int'(in_ready), 0);
      l = 0;
      for (int k = 0; k < 3; k++) if (m[k]) l = 2 * k;
      for (int k = 0; k < 3; k++) if (m[k]) cur[k][wa[k]] = wd[k];
      ep++;
      for (int k = 0; k < 3; k++)
        for (int a = 0; a < D; a++) eps[ep][k][a] = cur[k][a];
      n = 0;
      for (int i = hd; i < tl; i++) begin
        if (ec - qa[i] <= l) begin
          qe[i] = ep; qs[i] = 1; qt[i] = ($countones(m) > 1) ? 3 : 1; n++;
        end else if (qt[i] == 0) qt[i] = 2;
      end
      after_sq = (n > 0);
    end
    if (iv && in_ready) begin
      qi[tl] = sidx; qe[tl] = ep; qa[tl] = ec + 1; qs[tl] = 0; qt[tl] = 0;
      tl++;
      sidx = (sidx + 1) % D;
    end
  endtask

  initial begin
    int wa[3], wd[3], z[3];
    z = '{0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);

    // Fill the three tables with arithmetic permutations.
    for (int a = 0; a < D; a++) begin
      wa = '{a, a, a};
      wd = '{(3 * a + 1) % D, (5 * a + 2) % D, (7 * a + 3) % D};
      cycle(0, 3'b111, wa, wd, 0);
    end
    repeat (2) cycle(0, 3'b000, z, z, 0);

    // Every index twice, back to back, no writes.
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < D; i++) cycle(1, 3'b000, z, z, 1);
    repeat (10) cycle(0, 3'b000, z, z, 0);

    // Each non-empty lane combination at three points of a full pipeline.
    for (int m = 1; m < 8; m++) begin
      for (int pos = 0; pos < 3; pos++) begin
        for (int c = 0; c < 28; c++) begin
          if (c == 8 + pos) begin
            wa[0] = (sidx + D - 1) % D;
            wa[1] = (c + 3 + pos) % D;
            wa[2] = (c + 6 + m) % D;
            for (int k = 0; k < 3; k++) wd[k] = (cur[k][wa[k]] + 1 + pos) % D;
            cycle(c < 22, 3'(m), wa, wd, 0);
          end else begin
            cycle(c < 22, 3'b000, z, z, 0);
          end
        end
        repeat (14) cycle(0, 3'b000, z, z, 0);
      end
    end

    repeat (16) cycle(0, 3'b000, z, z, 0);
    chk(hd == tl, "R4", tl - hd, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", tl - hd, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule